// File: doc/BRIEF.md
# Windowed Inbound Address Translator

This block turns the 34-bit address carried by an inbound request into a local address for an on-chip memory-mapped master. Software sets up a bank of mapping windows through a 32-bit register port. Each window holds a base address, a mask that picks which address bits must agree with the base, an enable flag, and an offset. The offset takes the place of the masked bits in the local address.

For each request, the block compares the address against every enabled window in parallel. When the request type is one that gets translated, the block reports a hit with the window index and the translated address. When no window matches, it reports a miss. Other request types pass through with neither flag set. The result is registered and appears one cycle after the request.

Top module: `iaddr_xlate`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_win` and `rsp_laddr` are all zero.
- R2: Window n has three registers. Its base sits at byte offset 0x300+0x10·n, its mask at 0x304+0x10·n and its local offset at 0x308+0x10·n. A write with `cfg_we` high takes effect at the next clock edge. `cfg_rdata` returns the addressed register without delay.
- R3: The base register holds base address bits [31:3] in data bits [31:3] and bits [33:32] in data bits [1:0]. Base bits [2:0] are always zero. Data bit 2 is reserved and reads as zero whatever was written.
- R4: The mask register uses the same layout, with mask bits [2:0] always zero. Data bit 2 is the window enable. A window whose enable is clear never matches.
- R5: An enabled window matches when (address AND mask) equals (base AND mask) across all 34 bits, including bits [33:32].
- R6: On a hit, `rsp_laddr` equals the window offset OR-ed with the low 32 address bits that the mask leaves clear.
- R7: When several enabled windows match, the lowest-numbered one is used, and its number appears on `rsp_win`.
- R8: A translatable request that matches no window gives `rsp_miss`=1, `rsp_hit`=0, `rsp_win`=0 and `rsp_laddr`=0. Hit and miss are never high together.
- R9: Only `req_type` codes 4'h2 (read), 4'h4 (write), 4'h5 (write with response) and 4'h6 (streaming write) are translated. Any other code gives `rsp_valid`=1 with `rsp_hit`=0, `rsp_miss`=0 and `rsp_laddr`=0.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Back-to-back requests give back-to-back results. In a cycle where `rsp_valid` is low, `rsp_hit` and `rsp_miss` are low.
- R11: Register-port addresses outside the window registers read as zero, and so does slot 0xC of each window. Writes to those addresses change no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 4 | Request type code |
| req_addr | input | 34 | Inbound request address |
| rsp_valid | output | 1 | Result for the previous cycle's request |
| rsp_hit | output | 1 | A window matched a translatable request |
| rsp_miss | output | 1 | No window matched a translatable request |
| rsp_win | output | 4 | Number of the window used |
| rsp_laddr | output | 32 | Translated local address |

## Verification
The assertions check the following on every cycle:
- result timing relative to `req_valid`;
- that hit and miss are exclusive, and that a miss drives a zero address;
- that untranslated types never raise a flag;
- that the window selection is one-hot and no lower-numbered matching window is passed over;
- that the reserved base bit reads as zero and that a mask write loads the enable.

Some behaviours need chosen addresses and programmed windows, so only the bench's directed scenarios can show them:
- the exact masked compare, including the two extended bits;
- the OR-merge of the offset into the local address;
- the fall-through to the next window when a higher-priority window is disabled;
- the register map, including the holes that read as zero.

// File: rtl/xlate_pkg.sv
`timescale 1ns/1ps
package xlate_pkg;

  localparam int XADDR_W = 34;

  typedef enum logic [3:0] {
    REQ_RD        = 4'h2,
    REQ_WR        = 4'h4,
    REQ_WR_ACK    = 4'h5,
    REQ_WR_STREAM = 4'h6
  } req_kind_e;

  typedef struct packed {
    logic [XADDR_W-1:0] base;
    logic [XADDR_W-1:0] mask;
    logic               en;
  } win_cfg_t;

  function automatic logic kind_is_xlate(logic [3:0] k);
    logic r;
    case (k)
      REQ_RD, REQ_WR, REQ_WR_ACK, REQ_WR_STREAM: r = 1'b1;
      default:                                   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xlate_regs.sv
`timescale 1ns/1ps
// Window register bank: per-window base, mask+enable and local offset.
// Requires LADDR_W <= 32 and the window span to fit in CFG_AW bits.
module xlate_regs
  import xlate_pkg::*;
#(
  parameter int NWIN    = 16,
  parameter int LADDR_W = 32,
  parameter int CFG_AW  = 12,
  parameter logic [CFG_AW-1:0] WIN_BASE = 'h300
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output win_cfg_t           win_cfg [NWIN],
  output logic [LADDR_W-1:0] win_ofs [NWIN]
);

  localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int SPAN  = NWIN * 16;

  logic [CFG_AW-1:0] rel;
  logic              in_rng;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        sel;
  logic [31:0]       rd_word [NWIN][4];

  assign rel    = cfg_addr - WIN_BASE;
  assign in_rng = (cfg_addr >= WIN_BASE) && (rel < CFG_AW'(SPAN));
  assign idx    = rel[4 +: IDX_W];
  assign sel    = rel[3:2];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic               sel_w;
    logic               wr_base, wr_mask, wr_ofs;
    logic [28:0]        base_lo_q, mask_lo_q;
    logic [1:0]         base_hi_q, mask_hi_q;
    logic               en_q;
    logic [LADDR_W-1:0] ofs_q;

    assign sel_w   = cfg_we && in_rng && (idx == IDX_W'(w));
    assign wr_base = sel_w && (sel == 2'd0);
    assign wr_mask = sel_w && (sel == 2'd1);
    assign wr_ofs  = sel_w && (sel == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_lo_q <= '0;
        base_hi_q <= '0;
        mask_lo_q <= '0;
        mask_hi_q <= '0;
        en_q      <= 1'b0;
        ofs_q     <= '0;
      end else begin
        if (wr_base) begin
          base_lo_q <= cfg_wdata[31:3];
          base_hi_q <= cfg_wdata[1:0];
        end
        if (wr_mask) begin
          mask_lo_q <= cfg_wdata[31:3];
          en_q      <= cfg_wdata[2];
          mask_hi_q <= cfg_wdata[1:0];
        end
        if (wr_ofs) begin
          ofs_q <= cfg_wdata[LADDR_W-1:0];
        end
      end
    end

    assign rd_word[w][0] = {base_lo_q, 1'b0, base_hi_q};
    assign rd_word[w][1] = {mask_lo_q, en_q, mask_hi_q};
    assign rd_word[w][2] = 32'(ofs_q);
    assign rd_word[w][3] = '0;

    assign win_cfg[w].base = {base_hi_q, base_lo_q, 3'b000};
    assign win_cfg[w].mask = {mask_hi_q, mask_lo_q, 3'b000};
    assign win_cfg[w].en   = en_q;
    assign win_ofs[w]      = ofs_q;

    // R4: a mask write loads the enable bit from data bit 2
    p_en_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> (en_q == $past(cfg_wdata[2])));
  end

  always_comb begin
    cfg_rdata = '0;
    if (in_rng) cfg_rdata = rd_word[idx][sel];
  end

  // R3: reserved base bit always reads zero
  p_base_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && sel == 2'd0) |-> !cfg_rdata[2]);

endmodule

// File: rtl/xlate_win_match.sv
`timescale 1ns/1ps
// One window: masked compare over the full request address and address merge.
module xlate_win_match
  import xlate_pkg::*;
#(
  parameter int LADDR_W = 32
) (
  input  logic [XADDR_W-1:0] req_addr,
  input  win_cfg_t           cfg,
  input  logic [LADDR_W-1:0] ofs,
  output logic               hit,
  output logic [LADDR_W-1:0] laddr
);

  logic [XADDR_W-1:0] diff;

  assign diff  = (req_addr ^ cfg.base) & cfg.mask;
  assign hit   = cfg.en && (diff == '0);
  assign laddr = ofs | (req_addr[LADDR_W-1:0] & ~cfg.mask[LADDR_W-1:0]);

endmodule

// File: rtl/xlate_prio_sel.sv
`timescale 1ns/1ps
// Lowest-index-wins selector over the per-window match vector.
module xlate_prio_sel #(
  parameter int NWIN    = 16,
  parameter int LADDR_W = 32,
  localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NWIN-1:0]    hit_vec,
  input  logic [LADDR_W-1:0] laddr_vec [NWIN],
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LADDR_W-1:0] win_laddr
);

  logic [NWIN-1:0] grant;

  always_comb begin
    grant     = '0;
    win_idx   = '0;
    win_laddr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        win_idx   = IDX_W'(i);
        win_laddr = laddr_vec[i];
      end
    end
  end

  assign any_hit = |hit_vec;

  // R7: at most one window granted
  p_grant_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R7: no matching window below the granted one
  p_grant_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (((grant - 1'b1) & hit_vec) == '0));

endmodule

// File: rtl/iaddr_xlate.sv
`timescale 1ns/1ps
module iaddr_xlate
  import xlate_pkg::*;
#(
  parameter int NWIN    = 16,
  parameter int LADDR_W = 32,
  parameter int CFG_AW  = 12,
  localparam int IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic [3:0]         req_type,
  input  logic [XADDR_W-1:0] req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic [IDX_W-1:0]   rsp_win,
  output logic [LADDR_W-1:0] rsp_laddr
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  win_cfg_t           win_cfg [NWIN];
  logic [LADDR_W-1:0] win_ofs [NWIN];
  logic [NWIN-1:0]    hit_vec;
  logic [LADDR_W-1:0] laddr_vec [NWIN];
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [LADDR_W-1:0] sel_laddr;

  xlate_regs #(
    .NWIN(NWIN), .LADDR_W(LADDR_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .win_cfg  (win_cfg),
    .win_ofs  (win_ofs)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    xlate_win_match #(.LADDR_W(LADDR_W)) u_match (
      .req_addr(req_addr),
      .cfg     (win_cfg[w]),
      .ofs     (win_ofs[w]),
      .hit     (hit_vec[w]),
      .laddr   (laddr_vec[w])
    );
  end

  xlate_prio_sel #(.NWIN(NWIN), .LADDR_W(LADDR_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit_vec  (hit_vec),
    .laddr_vec(laddr_vec),
    .any_hit  (any_hit),
    .win_idx  (sel_idx),
    .win_laddr(sel_laddr)
  );

  // next-state
  logic               xl_req;
  logic               ld;
  logic               nxt_hit, nxt_miss;
  logic [IDX_W-1:0]   nxt_win;
  logic [LADDR_W-1:0] nxt_laddr;

  always_comb begin
    xl_req    = req_valid && kind_is_xlate(req_type);
    ld        = req_valid || rsp_valid;
    nxt_hit   = xl_req && any_hit;
    nxt_miss  = xl_req && !any_hit;
    nxt_win   = nxt_hit ? sel_idx : '0;
    nxt_laddr = nxt_hit ? sel_laddr : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_laddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (ld) begin
        rsp_hit   <= nxt_hit;
        rsp_miss  <= nxt_miss;
        rsp_win   <= nxt_win;
        rsp_laddr <= nxt_laddr;
      end
    end
  end

  // R10: one-cycle result timing
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));
  // R8: exclusive flags, miss carries no address
  p_hit_miss_excl_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rsp_hit && rsp_miss));
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_miss |-> (rsp_laddr == '0));
  // R9: untranslated types raise no flag
  p_types_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !kind_is_xlate(req_type)) |=> (!rsp_hit && !rsp_miss && rsp_laddr == '0));

endmodule

// File: tb/sim_iaddr_xlate.sv
`timescale 1ns/1ps
module sim_iaddr_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic [3:0]  req_type;
  logic [33:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [3:0]  rsp_win;
  logic [31:0] rsp_laddr;

  int vec_cnt = 0;
  int bad_cnt = 0;

  // bench-side window model
  logic [33:0] m_base [16];
  logic [33:0] m_mask [16];
  logic        m_en   [16];
  logic [31:0] m_ofs  [16];

  always #2.5 clk = ~clk;

  iaddr_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_type(req_type), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_win(rsp_win), .rsp_laddr(rsp_laddr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [33:0] v, input logic b2);
    return {v[31:3], b2, v[33:32]};
  endfunction

  task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic prog(input int w, input logic [33:0] b, input logic [33:0] m,
                      input logic en, input logic [31:0] o);
    cfg_wr(12'h300 + 12'(w * 16), enc(b, 1'b0));
    cfg_wr(12'h304 + 12'(w * 16), enc(m, en));
    cfg_wr(12'h308 + 12'(w * 16), o);
    m_base[w] = {b[33:3], 3'b000};
    m_mask[w] = {m[33:3], 3'b000};
    m_en[w]   = en;
    m_ofs[w]  = o;
  endtask

  task automatic model(input logic [3:0] t, input logic [33:0] a,
                       output logic h, output logic mi,
                       output logic [3:0] wn, output logic [31:0] la);
    logic xl;
    xl = (t == 4'h2) || (t == 4'h4) || (t == 4'h5) || (t == 4'h6);
    h = 1'b0; mi = 1'b0; wn = '0; la = '0;
    if (xl) begin
      for (int w = 15; w >= 0; w--) begin
        if (m_en[w] && (((a ^ m_base[w]) & m_mask[w]) == '0)) begin
          h = 1'b1; wn = 4'(w); la = m_ofs[w] | (a[31:0] & ~m_mask[w][31:0]);
        end
      end
      mi = !h;
    end
  endtask

  task automatic check_rsp(input string tag, input logic [3:0] t, input logic [33:0] a);
    logic h, mi; logic [3:0] wn; logic [31:0] la;
    model(t, a, h, mi, wn, la);
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"},   64'(rsp_hit),   64'(h));
    chk({tag, " miss"},  64'(rsp_miss),  64'(mi));
    chk({tag, " win"},   64'(rsp_win),   64'(wn));
    chk({tag, " laddr"}, 64'(rsp_laddr), 64'(la));
  endtask

  task automatic send(input string tag, input logic [3:0] t, input logic [33:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, t, a);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 rsp_valid", 64'(rsp_valid), 0);
    chk("R1 rsp_hit",   64'(rsp_hit), 0);
    chk("R1 rsp_miss",  64'(rsp_miss), 0);
    chk("R1 rsp_laddr", 64'(rsp_laddr), 0);
    for (int w = 0; w < 16; w += 5) begin
      cfg_rd(12'h300 + 12'(w * 16), d); chk("R1 base reset", 64'(d), 0);
      cfg_rd(12'h304 + 12'(w * 16), d); chk("R1 mask reset", 64'(d), 0);
      cfg_rd(12'h308 + 12'(w * 16), d); chk("R1 ofs reset",  64'(d), 0);
    end
    send("R1 R8 miss after reset", 4'h2, 34'h0_0000_0000);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    cfg_wr(12'h330, 32'hFFFF_FFFF);
    cfg_rd(12'h330, d); chk("R3 base rsvd bit", 64'(d), 64'hFFFF_FFFB);
    cfg_wr(12'h334, 32'hFFFF_FFFB);
    cfg_rd(12'h334, d); chk("R4 mask readback", 64'(d), 64'hFFFF_FFFB);
    cfg_wr(12'h338, 32'hA5A5_0001);
    cfg_rd(12'h338, d); chk("R2 ofs readback", 64'(d), 64'hA5A5_0001);
    cfg_rd(12'h3F8, d); chk("R2 other window untouched", 64'(d), 0);
    prog(3, 34'h0, 34'h0, 1'b0, 32'h0);
    cfg_rd(12'h330, d); chk("R2 base cleared", 64'(d), 0);
  endtask

  task automatic t_basic;
    prog(2, 34'h0_8000_0000, 34'h3_F000_0000, 1'b1, 32'h0010_0000);
    send("R5 R6 basic hit", 4'h2, 34'h0_8123_4567);
    chk("R6 merged laddr", 64'(rsp_laddr), 64'h0133_4567);
    send("R5 ext bit mismatch", 4'h4, 34'h1_8123_4567);
    chk("R5 ext miss", 64'(rsp_miss), 1);
    prog(5, 34'h2_0000_0000, 34'h3_0000_0000, 1'b1, 32'h0);
    send("R5 ext bits hit", 4'h5, 34'h2_1234_5678);
    chk("R5 ext win", 64'(rsp_win), 5);
    send("R8 full miss", 4'h6, 34'h1_0000_0040);
  endtask

  task automatic t_priority;
    prog(9, 34'h0_4000_0000, 34'h3_FFFF_0000, 1'b1, 32'h9000_0000);
    prog(7, 34'h0_4000_0000, 34'h3_FF00_0000, 1'b1, 32'h7000_0000);
    send("R7 lowest wins", 4'h2, 34'h0_4000_1234);
    chk("R7 win7", 64'(rsp_win), 7);
    prog(7, 34'h0_4000_0000, 34'h3_FF00_0000, 1'b0, 32'h7000_0000);
    send("R4 disabled falls to next", 4'h2, 34'h0_4000_1234);
    chk("R4 win9", 64'(rsp_win), 9);
    prog(1, 34'h0, 34'h0, 1'b1, 32'h0000_0000);
    send("R7 catch-all window 1", 4'h4, 34'h0_4000_1234);
    chk("R7 win1", 64'(rsp_win), 1);
    prog(1, 34'h0, 34'h0, 1'b0, 32'h0);
  endtask

  task automatic t_types;
    logic [3:0] bad_t [6] = '{4'h0, 4'h1, 4'h3, 4'h7, 4'h8, 4'hF};
    logic [3:0] ok_t  [4] = '{4'h2, 4'h4, 4'h5, 4'h6};
    foreach (bad_t[i]) send("R9 untranslated type", bad_t[i], 34'h0_8000_0010);
    foreach (ok_t[i])  send("R9 translated type",   ok_t[i],  34'h0_8000_0010);
  endtask

  task automatic t_backtoback;
    @(negedge clk);
    req_valid = 1'b1; req_type = 4'h2; req_addr = 34'h0_8000_0100;
    @(negedge clk);
    check_rsp("R10 first of pair", 4'h2, 34'h0_8000_0100);
    req_type = 4'h4; req_addr = 34'h1_0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R10 second of pair", 4'h4, 34'h1_0000_0000);
    @(negedge clk);
    chk("R10 idle valid", 64'(rsp_valid), 0);
    chk("R10 idle hit",   64'(rsp_hit), 0);
    chk("R10 idle miss",  64'(rsp_miss), 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    cfg_wr(12'h30C, 32'hFFFF_FFFF);
    cfg_wr(12'h2FC, 32'hFFFF_FFFF);
    cfg_wr(12'h400, 32'hFFFF_FFFF);
    cfg_rd(12'h30C, d); chk("R11 slot C reads 0", 64'(d), 0);
    cfg_rd(12'h2FC, d); chk("R11 below range", 64'(d), 0);
    cfg_rd(12'h400, d); chk("R11 above range", 64'(d), 0);
    cfg_rd(12'h300, d); chk("R11 window0 base intact", 64'(d), 0);
    cfg_rd(12'h304, d); chk("R11 window0 mask intact", 64'(d), 0);
    send("R11 translation unchanged", 4'h2, 34'h0_8123_4567);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_cnt++;
    $display("FAIL watchdog R10 run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    for (int w = 0; w < 16; w++) begin
      m_base[w] = '0; m_mask[w] = '0; m_en[w] = 1'b0; m_ofs[w] = '0;
    end
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_type = '0; req_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regmap();
    t_basic();
    t_priority();
    t_types();
    t_backtoback();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule